// File: doc/BRIEF.md
# Keyboard Code FIFO Interface

This block sits between a PS/2 scan-code receiver and a 32-bit memory-mapped bus. The receiver hands over one byte at a time through a byte-valid strobe. Each byte becomes one entry in a deep first-in first-out buffer. An entry holds the raw scan code together with an ASCII character. The character comes from a fixed UK-layout lookup, and the lookup can be changed only by rebuilding the hardware.

A small front end follows the shift keys through their make and break codes, so letters come out in upper case and digits come out as their shifted symbols while a shift key is held. Release codes, extension prefixes and keys with no printable meaning are stored with an ASCII value of zero.

The bus sees two word addresses. A read of the data address shows the oldest entry without removing it. A read of the status address returns the pending count, an empty flag, a full flag and a sticky overflow flag. A write of any value, at either address, removes the oldest entry.

Top module: `kbd_code_fifo`

## Requirements
- R1: After reset the status word reads 0x0000_0400: count 0, empty set, full clear, overflow clear. The data word reads 0.
- R2: When `bus_addr` is 0, `bus_rdata` shows the oldest entry. The scan code is in bits 7:0, the ASCII value is in bits 15:8, and bits 31:16 are zero. When the buffer is empty the data word reads 0.
- R3: When `bus_addr` is 1, `bus_rdata` is the status word. The pending count is in bits 9:0, empty is bit 10, full is bit 11 and overflow is bit 12. All other bits are zero.
- R4: The buffer holds 512 entries. Entries leave in the order they arrived, and each accepted byte raises the count by one on the next clock.
- R5: Reading never removes an entry. A `bus_wr` pulse with any data, at either address, removes exactly one entry. A write while the buffer is empty leaves the count at 0.
- R6: When a byte arrives while the buffer is full, the byte is dropped, the stored entries stay unchanged and the overflow bit is set. The overflow bit stays set until a write removes an entry. If a dropped byte and a removal happen in the same cycle, the bit stays set.
- R7: With no shift key held, the ASCII value is as follows:
  - Letter keys give lower-case letters, for example scan code 0x1C gives 0x61.
  - Digit keys give '0' to '9', for example 0x16 gives 0x31 and 0x45 gives 0x30.
  - 0x29 gives 0x20 (space).
  - 0x5A gives 0x0D (carriage return).
- R8: While a shift key is held, letters give upper case. The digits 1 to 0 give `! " (0) $ % ^ & * ( )` on the UK layout, where 3 has no ASCII symbol and gives 0.
  - A shift key is held from its make code (0x12 or 0x59) until the sequence 0xF0 followed by the same code.
  - A byte uses the shift state from before that byte arrived.
- R9: The ASCII value is 0 for the release prefix 0xF0, the extension prefix 0xE0, the byte that follows 0xF0, the shift codes themselves and any other unmapped code. The raw byte is still stored.
- R10: When a byte arrives and a write occurs in the same cycle, with the buffer neither empty nor full, the count stays the same and the new byte joins the tail behind the remaining entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kb_valid | input | 1 | One-cycle strobe: `kb_code` holds a received byte |
| kb_code | input | 8 | Received scan-code byte |
| bus_wr | input | 1 | Bus write strobe; removes the oldest entry |
| bus_addr | input | 1 | Word select: 0 = data, 1 = status |
| bus_rdata | output | 32 | Read data for the selected word |

## Verification
The assertions assume that `kb_valid` and `bus_wr` are single-cycle, known-valued strobes sampled on the rising edge, and that every byte arrival counts as an attempted push whether or not the shift tracker uses it. The bench keeps to this by driving every input on the falling edge and holding it for one full cycle. It mixes random byte arrivals, drawn mostly from the mapped codes, prefixes and shift codes, with random writes at both addresses. Directed sequences reach the full, overflow and empty-write edges that random traffic seldom hits.

// File: rtl/kbd_pkg.sv
package kbd_pkg;

    localparam logic [7:0] SC_RELEASE = 8'hF0;
    localparam logic [7:0] SC_EXTEND  = 8'hE0;
    localparam logic [7:0] SC_LSHIFT  = 8'h12;
    localparam logic [7:0] SC_RSHIFT  = 8'h59;

    typedef struct packed {
        logic [7:0] ascii;
        logic [7:0] code;
    } kbd_entry_t;

    localparam int ENTRY_W = $bits(kbd_entry_t);

    function automatic logic [7:0] letter_of(input logic [7:0] c);
        case (c)
            8'h1C: return 8'h61; 8'h32: return 8'h62; 8'h21: return 8'h63;
            8'h23: return 8'h64; 8'h24: return 8'h65; 8'h2B: return 8'h66;
            8'h34: return 8'h67; 8'h33: return 8'h68; 8'h43: return 8'h69;
            8'h3B: return 8'h6A; 8'h42: return 8'h6B; 8'h4B: return 8'h6C;
            8'h3A: return 8'h6D; 8'h31: return 8'h6E; 8'h44: return 8'h6F;
            8'h4D: return 8'h70; 8'h15: return 8'h71; 8'h2D: return 8'h72;
            8'h1B: return 8'h73; 8'h2C: return 8'h74; 8'h3C: return 8'h75;
            8'h2A: return 8'h76; 8'h1D: return 8'h77; 8'h22: return 8'h78;
            8'h35: return 8'h79; 8'h1A: return 8'h7A;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] digit_of(input logic [7:0] c);
        case (c)
            8'h45: return 8'h30; 8'h16: return 8'h31; 8'h1E: return 8'h32;
            8'h26: return 8'h33; 8'h25: return 8'h34; 8'h2E: return 8'h35;
            8'h36: return 8'h36; 8'h3D: return 8'h37; 8'h3E: return 8'h38;
            8'h46: return 8'h39;
            default: return 8'h00;
        endcase
    endfunction

    // UK shifted digit row; pound sign has no ASCII code
    function automatic logic [7:0] uk_shift_digit(input logic [7:0] d);
        case (d)
            8'h31: return 8'h21; 8'h32: return 8'h22; 8'h33: return 8'h00;
            8'h34: return 8'h24; 8'h35: return 8'h25; 8'h36: return 8'h5E;
            8'h37: return 8'h26; 8'h38: return 8'h2A; 8'h39: return 8'h28;
            8'h30: return 8'h29;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] translate(input logic [7:0] c, input logic shifted);
        logic [7:0] l;
        logic [7:0] d;
        l = letter_of(c);
        d = digit_of(c);
        if (l != 8'h00)      return shifted ? (l - 8'h20) : l;
        else if (d != 8'h00) return shifted ? uk_shift_digit(d) : d;
        else if (c == 8'h29) return 8'h20;
        else if (c == 8'h5A) return 8'h0D;
        else                 return 8'h00;
    endfunction

    function automatic logic is_shift(input logic [7:0] c);
        return (c == SC_LSHIFT) || (c == SC_RSHIFT);
    endfunction

endpackage

// File: rtl/kbd_xlate.sv
module kbd_xlate
    import kbd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_code,
    output kbd_entry_t entry
);
    logic release_q;
    logic shift_q;

    always_comb begin
        entry.code = in_code;
        if (release_q || in_code == SC_RELEASE || in_code == SC_EXTEND)
            entry.ascii = 8'h00;
        else
            entry.ascii = translate(in_code, shift_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            release_q <= 1'b0;
            shift_q   <= 1'b0;
        end else if (in_valid) begin
            if (in_code == SC_RELEASE) begin
                release_q <= 1'b1;
            end else if (in_code != SC_EXTEND) begin
                release_q <= 1'b0;
                if (is_shift(in_code))
                    shift_q <= ~release_q;
            end
        end
    end
endmodule

// File: rtl/kbd_fifo.sv
module kbd_fifo #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_req,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop_req,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    count,
    output logic             empty,
    output logic             full,
    output logic             overflow
);
    logic [WIDTH-1:0] store [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic             push_ok;
    logic             pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign push_ok = push_req && !full;
    assign pop_ok  = pop_req && !empty;
    assign head    = empty ? '0 : store[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok)
            store[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
            overflow <= (overflow && !pop_req) || (push_req && full);
        end
    end
endmodule

// File: rtl/kbd_code_fifo.sv
module kbd_code_fifo
    import kbd_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        kb_valid,
    input  logic [7:0]  kb_code,
    input  logic        bus_wr,
    input  logic        bus_addr,
    output logic [31:0] bus_rdata
);
    localparam int STAT_CNT_W = 10;

    kbd_entry_t          new_entry;
    logic [ENTRY_W-1:0]  head_bits;
    logic [CW-1:0]       occ;
    logic                empty_w;
    logic                full_w;
    logic                ovf_w;
    logic [31:0]         stat_word;

    kbd_xlate u_xlate (
        .clk      (clk),
        .rst      (rst),
        .in_valid (kb_valid),
        .in_code  (kb_code),
        .entry    (new_entry)
    );

    kbd_fifo #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push_req  (kb_valid),
        .push_data (new_entry),
        .pop_req   (bus_wr),
        .head      (head_bits),
        .count     (occ),
        .empty     (empty_w),
        .full      (full_w),
        .overflow  (ovf_w)
    );

    always_comb begin
        stat_word = '0;
        stat_word[STAT_CNT_W-1:0] = STAT_CNT_W'(occ);
        stat_word[10] = empty_w;
        stat_word[11] = full_w;
        stat_word[12] = ovf_w;
    end

    assign bus_rdata = bus_addr ? stat_word : {16'h0000, head_bits};
endmodule

// File: rtl/kbd_code_fifo_chk.sv
module kbd_code_fifo_chk #(
    parameter int DEPTH = 512,
    parameter int CW = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          kb_valid,
    input logic          bus_wr,
    input logic [CW-1:0] count,
    input logic          full,
    input logic          ovf
);
    p_count_bound_r4: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    p_push_inc_r4: assert property (@(posedge clk) disable iff (rst)
        kb_valid && !bus_wr && !full |=> count == $past(count) + CW'(1));

    p_pop_dec_r5: assert property (@(posedge clk) disable iff (rst)
        bus_wr && !kb_valid && count != '0 |=> count == $past(count) - CW'(1));

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !bus_wr && !kb_valid |=> $stable(count));

    p_ovf_set_r6: assert property (@(posedge clk) disable iff (rst)
        kb_valid && full |=> ovf);

    p_ovf_clr_r6: assert property (@(posedge clk) disable iff (rst)
        bus_wr && !(kb_valid && full) |=> !ovf);

    p_both_hold_r10: assert property (@(posedge clk) disable iff (rst)
        kb_valid && bus_wr && count != '0 && !full |=> $stable(count));
endmodule

bind kbd_code_fifo kbd_code_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .kb_valid (kb_valid),
    .bus_wr   (bus_wr),
    .count    (occ),
    .full     (full_w),
    .ovf      (ovf_w)
);

// File: tb/tb_kbd_code_fifo.sv
module tb_kbd_code_fifo;
    localparam int DEPTH = 512;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        kb_valid = 1'b0;
    logic [7:0]  kb_code = 8'h00;
    logic        bus_wr = 1'b0;
    logic        bus_addr = 1'b0;
    logic [31:0] bus_rdata;

    always #10 clk = ~clk;

    kbd_code_fifo #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .kb_valid(kb_valid), .kb_code(kb_code),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference tables, letters a..z and digits 0..9
    logic [7:0] let_sc [26] = '{8'h1C,8'h32,8'h21,8'h23,8'h24,8'h2B,8'h34,8'h33,8'h43,
                                8'h3B,8'h42,8'h4B,8'h3A,8'h31,8'h44,8'h4D,8'h15,8'h2D,
                                8'h1B,8'h2C,8'h3C,8'h2A,8'h1D,8'h22,8'h35,8'h1A};
    logic [7:0] dig_sc [10] = '{8'h45,8'h16,8'h1E,8'h26,8'h25,8'h2E,8'h36,8'h3D,8'h3E,8'h46};
    logic [7:0] dig_up [10] = '{8'h29,8'h21,8'h22,8'h00,8'h24,8'h25,8'h5E,8'h26,8'h2A,8'h28};

    // bench model
    logic [15:0] mq[$];
    bit m_shift = 0;
    bit m_rel = 0;
    bit m_ovf = 0;

    function automatic logic [7:0] ref_ascii(input logic [7:0] c, input bit sh, input bit rel);
        if (rel || c == 8'hF0 || c == 8'hE0) return 8'h00;
        for (int i = 0; i < 26; i++)
            if (let_sc[i] == c) return sh ? 8'(8'h41 + i) : 8'(8'h61 + i);
        for (int i = 0; i < 10; i++)
            if (dig_sc[i] == c) return sh ? dig_up[i] : 8'(8'h30 + i);
        if (c == 8'h29) return 8'h20;
        if (c == 8'h5A) return 8'h0D;
        return 8'h00;
    endfunction

    function automatic logic [31:0] exp_status();
        logic [31:0] s;
        s = '0;
        s[9:0] = 10'(mq.size());
        s[10] = (mq.size() == 0);
        s[11] = (mq.size() == DEPTH);
        s[12] = m_ovf;
        return s;
    endfunction

    function automatic logic [31:0] exp_data();
        return (mq.size() == 0) ? 32'h0 : {16'h0, mq[0]};
    endfunction

    task automatic model_step(input bit v, input logic [7:0] c, input bit w);
        bit was_full;
        logic [15:0] e;
        was_full = (mq.size() == DEPTH);
        e = {ref_ascii(c, m_shift, m_rel), c};
        m_ovf = (m_ovf && !w) || (v && was_full);
        if (v) begin
            if (c == 8'hF0) m_rel = 1;
            else if (c != 8'hE0) begin
                if (c == 8'h12 || c == 8'h59) m_shift = !m_rel;
                m_rel = 0;
            end
        end
        if (w && mq.size() > 0) void'(mq.pop_front());
        if (v && !was_full) mq.push_back(e);
    endtask

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic cyc(input bit v, input logic [7:0] c, input bit w, input bit a);
        kb_valid = v; kb_code = c; bus_wr = w; bus_addr = a;
        @(posedge clk);
        model_step(v, c, w);
        @(negedge clk);
        kb_valid = 0; bus_wr = 0;
    endtask

    task automatic compare(input string tag);
        bus_addr = 0; #1;
        check({tag, " data"}, bus_rdata, exp_data());
        bus_addr = 1; #1;
        check({tag, " status"}, bus_rdata, exp_status());
    endtask

    task automatic push(input logic [7:0] c); cyc(1, c, 0, 0); endtask
    task automatic pop();                     cyc(0, 8'h00, 1, 0); endtask

    task automatic drain(input string tag);
        while (mq.size() > 0) begin
            compare(tag);
            pop();
        end
        compare(tag);
    endtask

    function automatic logic [7:0] pick_code();
        int k;
        k = $urandom_range(0, 9);
        case (k)
            0, 1, 2: return let_sc[$urandom_range(0, 25)];
            3, 4:    return dig_sc[$urandom_range(0, 9)];
            5:       return 8'hF0;
            6:       return ($urandom_range(0, 1) == 0) ? 8'h12 : 8'h59;
            7:       return ($urandom_range(0, 1) == 0) ? 8'h29 : 8'h5A;
            8:       return 8'hE0;
            default: return 8'($urandom);
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24680));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        bus_addr = 1; #1; check("R1 status", bus_rdata, 32'h0000_0400);
        bus_addr = 0; #1; check("R1 data", bus_rdata, 32'h0);

        // R5 write when empty
        cyc(0, 8'h00, 1, 1);
        compare("R5 empty write");

        // R7 unshifted, R2 layout
        push(8'h1C); push(8'h5A); push(8'h29); push(8'h45);
        bus_addr = 0; #1; check("R2 R7 letter a", bus_rdata, 32'h0000_611C);
        #1; check("R5 read does not pop", bus_rdata, 32'h0000_611C);
        bus_addr = 1; #1; check("R3 count 4", bus_rdata, 32'h0000_0004);
        cyc(0, 8'h00, 1, 1);  // R5 write at status address pops
        bus_addr = 0; #1; check("R7 enter", bus_rdata, 32'h0000_0D5A);
        pop();
        bus_addr = 0; #1; check("R7 space", bus_rdata, 32'h0000_2029);
        pop();
        bus_addr = 0; #1; check("R7 digit 0", bus_rdata, 32'h0000_3045);
        pop();
        compare("R5 drained");

        // R8 shift, R9 non-printables
        push(8'h12); push(8'h1C); push(8'h16); push(8'h26);
        push(8'hF0); push(8'h12); push(8'h1C); push(8'hE0); push(8'h77);
        push(8'h59); push(8'h1E); push(8'hF0); push(8'h59); push(8'h1E);
        bus_addr = 0; #1; check("R9 shift code", bus_rdata, 32'h0000_0012);
        pop();
        bus_addr = 0; #1; check("R8 upper A", bus_rdata, 32'h0000_411C);
        pop();
        bus_addr = 0; #1; check("R8 bang", bus_rdata, 32'h0000_2116);
        pop();
        bus_addr = 0; #1; check("R8 pound gives 0", bus_rdata, 32'h0000_0026);
        pop();
        bus_addr = 0; #1; check("R9 release prefix", bus_rdata, 32'h0000_00F0);
        pop();
        drain("R8 R9 sequence");

        // R6 fill, overflow, sticky, clear by pop; R4 order
        for (int i = 0; i < DEPTH; i++) push(pick_code());
        bus_addr = 1; #1; check("R4 R6 full status", bus_rdata, 32'h0000_0A00);
        push(8'h1C);
        compare("R6 dropped byte");
        bus_addr = 1; #1; check("R6 overflow set", bus_rdata, 32'h0000_1A00);
        repeat (3) cyc(0, 8'h00, 0, 0);
        compare("R6 overflow sticky");
        cyc(1, 8'h1C, 1, 0);
        compare("R6 full push with pop");
        pop();
        compare("R6 overflow cleared");
        bus_addr = 1; #1; check("R6 cleared status", bus_rdata, 32'h0000_01FE);

        // R10 simultaneous push and pop
        for (int i = 0; i < 20; i++) begin
            cyc(1, pick_code(), 1, i[0]);
            compare("R10 push+pop");
        end
        drain("R4 order after fill");

        // random traffic
        for (int i = 0; i < 6000; i++) begin
            bit v;
            bit w;
            v = ($urandom_range(0, 99) < 55);
            w = ($urandom_range(0, 99) < 45);
            cyc(v, pick_code(), w, 1'($urandom_range(0, 1)));
            compare("R4 R5 R7 R8 R9 random");
        end
        drain("R4 random drain");

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule